// File: doc/BRIEF.md
# Cascaded Delay-and-Sum Receive Slice

This block is one slice of a receive beamformer. Each accepted input beat carries one signed 12-bit sample for each of 16 channels, plus a signed 18-bit partial sum from the slice before it in the chain. Every channel keeps its own history of past samples. From that history the slice selects the sample that lies a per-channel number of beats in the past. It adds the 16 selected samples, adds the incoming partial sum, and passes the total to the next slice. Four slices in a chain give a 64-channel beam sum, and the last slice in the chain delivers the full beam value. The clock is 40 MHz and the slice takes one beat per cycle.

An external controller writes per-channel delays through a simple load port while the scan runs. These writes go into a shadow bank. The shadow bank is copied into the working bank only on a beat that carries the line-start flag, so a line never mixes delays from two sets.

Both streams use valid/ready. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high, and a result is taken when `out_valid` and `out_ready` are both high. The whole pipeline advances together whenever its output register is empty or is being taken. `in_ready` therefore equals `!out_valid || out_ready`. While the output is held, nothing moves.

Top module: `bfs_slice`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: For each accepted beat, the output equals `in_casc` plus the sum over channels of the sample selected for that channel. With `out_ready` held high, the result appears with `out_valid` exactly 3 cycles after acceptance.
- R3: A delay of d picks the sample accepted d beats before the current beat. A delay of 0 picks the current beat's own sample. Delays run from 0 to 255.
- R4: If a delay reaches back to before the first beat accepted since reset, that channel contributes zero.
- R5: A write on the load port (channel in `dly_wr_ch`, value in `dly_wr_val`) updates only the shadow bank. The shadow bank is copied into the working bank on an accepted beat with `in_line_start` high, and that beat already uses the copied set. A load in the same cycle as that beat is not part of the copy. Without a line-start beat, loads have no effect on the output.
- R6: While `out_valid` is high and `out_ready` is low, `out_sum` and `out_valid` hold their values and `in_ready` is low.
- R7: History and delays count accepted beats only. Cycles without an accepted beat do not age the samples.
- R8: Each accepted beat produces exactly one output, in order. Cycles with no accepted beat produce no output.
- R9: `in_casc` and `out_sum` are 18-bit two's complement. The 16-channel sum is sign-extended before it is added, and the addition wraps modulo 2^18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Slice can take a beat |
| in_data | input | 192 | 16 signed samples; channel c at bits [12c+11:12c] |
| in_line_start | input | 1 | Beat opens a new line; commits the shadow delays |
| in_casc | input | 18 | Signed partial sum from the previous slice |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Next slice takes the result |
| out_sum | output | 18 | Signed total passed to the next slice |
| dly_wr_en | input | 1 | Write one shadow delay |
| dly_wr_ch | input | 4 | Channel whose shadow delay is written |
| dly_wr_val | input | 8 | Delay in beats |

## Verification
The first stream uses a staircase of delays from 0 to 255 across the channels, starting right after reset. This separates correct history indexing from off-by-one errors, and it shows whether channels that reach back before reset contribute zero. A second stream adds random input gaps and random output back-pressure, which tells apart aging by accepted beats from aging by clock cycles and checks that held results stay stable. A third stream loads random delays at random times and raises line-start only now and then, which exposes early commits and same-cycle load ordering. A last stream drives full-scale samples and cascade values to force sign extension and 18-bit wrap.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int BFS_NCH  = 16;  // channels per slice
  localparam int BFS_SW   = 12;  // sample width
  localparam int BFS_DW   = 8;   // delay width; history depth is 2**BFS_DW
  localparam int BFS_CW   = 18;  // cascade width
  localparam int BFS_LAT  = 3;   // beats from input to output register
endpackage

// File: rtl/bfs_lane.sv
// One channel: circular sample history plus the delayed tap register.
module bfs_lane #(
  parameter int SW = bfs_pkg::BFS_SW,
  parameter int DW = bfs_pkg::BFS_DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 acc,
  input  logic [DW-1:0]        wptr,
  input  logic [DW-1:0]        hist,
  input  logic [DW-1:0]        dly,
  input  logic signed [SW-1:0] smp,
  output logic signed [SW-1:0] tap
);
  localparam int DEPTH = 1 << DW;

  logic signed [SW-1:0] mem [DEPTH];
  logic [DW-1:0]        rd_addr;
  logic signed [SW-1:0] sel;

  always_ff @(posedge clk) begin
    if (acc) mem[wptr] <= smp;
  end

  always_comb begin
    rd_addr = wptr - dly;
    if (dly == '0)       sel = smp;
    else if (dly > hist) sel = '0;
    else                 sel = mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tap <= '0;
    else if (adv) tap <= sel;
  end

  AST_PRE_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && dly != '0 && dly > hist) |=> (tap == '0)); // R4
  AST_ZERO_DLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && dly == '0) |=> (tap == $past(smp))); // R3
endmodule

// File: rtl/bfs_dly_bank.sv
// Shadow and working delay registers with commit on line start.
module bfs_dly_bank #(
  parameter int NCH = bfs_pkg::BFS_NCH,
  parameter int DW  = bfs_pkg::BFS_DW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NCH)-1:0]  wr_ch,
  input  logic [DW-1:0]           wr_val,
  input  logic                    commit,
  output logic [NCH*DW-1:0]       eff
);
  logic [NCH*DW-1:0] shadow;
  logic [NCH*DW-1:0] active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (commit) active <= shadow;
      if (wr_en)  shadow[wr_ch*DW +: DW] <= wr_val;
    end
  end

  // The committing beat already sees the shadow set.
  assign eff = commit ? shadow : active;

  AST_WORKING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active)); // R5
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active == $past(shadow))); // R5
endmodule

// File: rtl/bfs_sum.sv
// Adds the channel taps, then adds the cascade word; carries valid alongside.
module bfs_sum #(
  parameter int NCH = bfs_pkg::BFS_NCH,
  parameter int SW  = bfs_pkg::BFS_SW,
  parameter int CW  = bfs_pkg::BFS_CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 in_valid,
  input  logic [NCH*SW-1:0]    taps,
  input  logic signed [CW-1:0] casc,
  output logic                 out_valid,
  output logic signed [CW-1:0] out_sum
);
  localparam int LW = SW + $clog2(NCH);

  logic                 v1, v2;
  logic signed [CW-1:0] c1, c2;
  logic signed [LW-1:0] tree, s2;

  always_comb begin
    tree = '0;
    for (int i = 0; i < NCH; i++) begin
      tree = tree + LW'($signed(taps[i*SW +: SW]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; out_valid <= 1'b0;
      c1 <= '0;   c2 <= '0;   s2 <= '0;  out_sum <= '0;
    end else if (adv) begin
      v1        <= in_valid;
      c1        <= casc;
      v2        <= v1;
      c2        <= c1;
      s2        <= tree;
      out_valid <= v2;
      out_sum   <= CW'(s2) + c2;
    end
  end

  AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !in_valid) |=> !v1); // R8
  AST_VALID_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && v2) |=> out_valid); // R8
endmodule

// File: rtl/bfs_slice.sv
module bfs_slice #(
  parameter int NCH = bfs_pkg::BFS_NCH,
  parameter int SW  = bfs_pkg::BFS_SW,
  parameter int DW  = bfs_pkg::BFS_DW,
  parameter int CW  = bfs_pkg::BFS_CW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NCH*SW-1:0]          in_data,
  input  logic                       in_line_start,
  input  logic signed [CW-1:0]       in_casc,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [CW-1:0]       out_sum,
  input  logic                       dly_wr_en,
  input  logic [$clog2(NCH)-1:0]     dly_wr_ch,
  input  logic [DW-1:0]              dly_wr_val
);
  logic              adv, acc, commit;
  logic [DW-1:0]     wptr, hist;
  logic [NCH*DW-1:0] eff;
  logic [NCH*SW-1:0] taps;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign acc      = in_valid && adv;
  assign commit   = acc && in_line_start;

  // Write pointer and saturating count of beats seen since reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      hist <= '0;
    end else if (acc) begin
      wptr <= wptr + 1'b1;
      if (hist != '1) hist <= hist + 1'b1;
    end
  end

  bfs_dly_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(dly_wr_en), .wr_ch(dly_wr_ch),
    .wr_val(dly_wr_val), .commit(commit), .eff(eff)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    bfs_lane #(.SW(SW), .DW(DW)) u_lane (
      .clk(clk), .rst_n(rst_n), .adv(adv), .acc(acc), .wptr(wptr),
      .hist(hist), .dly(eff[c*DW +: DW]), .smp(in_data[c*SW +: SW]),
      .tap(taps[c*SW +: SW])
    );
  end

  bfs_sum #(.NCH(NCH), .SW(SW), .CW(CW)) u_sum (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
    .taps(taps), .casc(in_casc), .out_valid(out_valid), .out_sum(out_sum)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum))); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((wptr - $past(wptr)) == DW'(1))); // R7
  AST_IDLE_NO_AGE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(wptr) && $stable(hist))); // R7
endmodule

// File: tb/bfs_slice_test.sv
module bfs_slice_test;
  localparam int NCH = 16;
  localparam int SW  = 12;
  localparam int DW  = 8;
  localparam int CW  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_line_start = 1'b0, out_ready = 1'b0;
  logic dly_wr_en = 1'b0;
  logic [3:0] dly_wr_ch = '0;
  logic [DW-1:0] dly_wr_val = '0;
  logic [NCH*SW-1:0] in_data = '0;
  logic signed [CW-1:0] in_casc = '0;
  logic in_ready, out_valid;
  logic signed [CW-1:0] out_sum;

  always #2.5 clk = ~clk;

  bfs_slice uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_line_start(in_line_start), .in_casc(in_casc),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum),
    .dly_wr_en(dly_wr_en), .dly_wr_ch(dly_wr_ch), .dly_wr_val(dly_wr_val)
  );

  int vecs = 0, bad = 0;
  bit done = 0;
  int shadow_m [NCH];
  int active_m [NCH];
  logic [NCH*SW-1:0]    xq [$];
  logic signed [CW-1:0] expq [$];
  string                tagq [$];
  bit hold_pend = 0;
  logic signed [CW-1:0] hold_val;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NCH*SW-1:0] rand_dat();
    logic [NCH*SW-1:0] d;
    for (int c = 0; c < NCH; c++) d[c*SW +: SW] = SW'($urandom);
    return d;
  endfunction

  task automatic model_accept(input bit ls, input logic [NCH*SW-1:0] dat,
                              input logic signed [CW-1:0] cs, input string tag);
    int sum, nb, d;
    logic [NCH*SW-1:0] old;
    if (ls) for (int c = 0; c < NCH; c++) active_m[c] = shadow_m[c];
    nb  = xq.size();
    sum = int'(cs);
    for (int c = 0; c < NCH; c++) begin
      d = active_m[c];
      if (d == 0) sum += int'($signed(dat[c*SW +: SW]));
      else if (d <= nb) begin
        old = xq[nb-d];
        sum += int'($signed(old[c*SW +: SW]));
      end
    end
    xq.push_back(dat);
    expq.push_back(CW'(sum));
    tagq.push_back(tag);
  endtask

  task automatic step(input bit iv, input bit ls, input bit le, input int lc, input int lv,
                      input bit ordy, input logic [NCH*SW-1:0] dat,
                      input logic signed [CW-1:0] cs, input string tag);
    logic signed [CW-1:0] e;
    string t;
    @(negedge clk);
    if (hold_pend)
      check("R6", out_valid && out_sum == hold_val, int'(out_sum), int'(hold_val));
    in_valid = iv; in_line_start = ls; dly_wr_en = le; dly_wr_ch = 4'(lc);
    dly_wr_val = DW'(lv); out_ready = ordy; in_data = dat; in_casc = cs;
    #1;
    if (out_valid && !ordy) check("R6", !in_ready, int'(in_ready), 0);
    if (out_valid && ordy) begin
      if (expq.size() == 0) check("R8", 1'b0, 1, 0);
      else begin
        e = expq.pop_front(); t = tagq.pop_front();
        check(t, out_sum == e, int'(out_sum), int'(e));
      end
    end
    hold_pend = out_valid && !ordy;
    hold_val  = out_sum;
    if (iv && in_ready) model_accept(ls, dat, cs, tag);
    if (le) shadow_m[lc] = lv;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; vecs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin shadow_m[c] = 0; active_m[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", !out_valid, int'(out_valid), 0);
    check("R1", in_ready, int'(in_ready), 1);

    // Staircase delays 0..255, streamed right after reset.
    for (int c = 0; c < NCH; c++) step(0, 0, 1, c, c*17, 1, '0, '0, "R5");
    for (int n = 0; n < 300; n++)
      step(1, n == 0, 0, 0, 0, 1, rand_dat(), CW'($urandom), n < 256 ? "R4" : "R3");
    // Three-cycle latency: one beat after idle, result after exactly 3 edges.
    step(0, 0, 0, 0, 0, 1, '0, '0, "R2");
    repeat (4) step(0, 0, 0, 0, 0, 1, '0, '0, "R2");
    @(negedge clk);
    in_valid = 1; in_data = rand_dat(); in_casc = 18'sd77; out_ready = 1; #1;
    model_accept(0, in_data, in_casc, "R2");
    @(negedge clk); in_valid = 0; #1; check("R2", !out_valid, int'(out_valid), 0);
    @(negedge clk); #1; check("R2", !out_valid, int'(out_valid), 0);
    @(negedge clk); #1; check("R2", out_valid, int'(out_valid), 1);
    begin
      logic signed [CW-1:0] e;
      e = expq.pop_front(); void'(tagq.pop_front());
      check("R2", out_sum == e, int'(out_sum), int'(e));
    end
    // Gaps and back-pressure.
    for (int n = 0; n < 500; n++)
      step(($urandom % 10) < 7, 0, 0, 0, 0, ($urandom % 10) < 6, rand_dat(),
           CW'($urandom), "R7");
    // Random loads, occasional line start.
    for (int n = 0; n < 600; n++) begin
      int pick = $urandom % 4;
      int v = (pick == 0) ? 0 : (pick == 1) ? 255 : int'($urandom % 256);
      step(($urandom % 10) < 8, (n % 37) == 5, ($urandom % 3) == 0, int'($urandom % NCH), v,
           ($urandom % 10) < 8, rand_dat(), CW'($urandom), "R5");
    end
    // Full-scale samples and cascade to force wrap.
    for (int n = 0; n < 120; n++) begin
      logic [NCH*SW-1:0] d;
      for (int c = 0; c < NCH; c++) d[c*SW +: SW] = ($urandom % 2) ? 12'h7FF : 12'h800;
      step(1, 0, 0, 0, 0, 1, d, ($urandom % 2) ? 18'sh1FFFF : -18'sh20000, "R9");
    end
    repeat (10) step(0, 0, 0, 0, 0, 1, '0, '0, "R8");
    check("R8", expq.size() == 0, expq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule